// File: doc/BRIEF.md
# Prioritised 64-Line Interrupt Controller

The controller collects 64 interrupt request lines, numbered 0 to 63, and drives one interrupt output towards a processor. Each line is first synchronised to the bus clock. Its own setup register then decides whether it is sensed by level or by rising edge, and gives it a 4-bit priority. Edge events are captured in a per-source latch. That latch holds the event until software rewrites the source's setup register.

Software sees the controller through a small 32-bit register bus. Each half of the source range (0–31 low, 32–63 high) has a write-one-to-set enable register and a write-one-to-clear disable register. A vector register reports the winning pending source. When nothing is pending it reads 64, which marks the read as spurious. Reading a valid vector puts the controller in service and holds the output low. Any write to the end-of-interrupt register leaves that state. A global-enable bit gates the output, and a soft-reset bit clears every register.

Register offsets (byte addresses): 0x000 enable-set low, 0x004 enable-set high, 0x008 disable low, 0x00C disable high, 0x010 vector, 0x014 end-of-interrupt, 0x018 soft reset (bit 0), 0x01C global enable (bit 0). Setup for source n sits at 0x200 + 8·n.

Top module: `irq_hub`

## Requirements
- R1: A write to enable-set low (0x000) or high (0x004) sets the mask bits where the data is 1 and keeps the others. Each register reads back the current 32-bit mask of its half.
- R2: A write to disable low (0x008) or high (0x00C) clears the mask bits where the data is 1 and keeps the others. Both disable registers read as zero.
- R3: The setup register of source n is at 0x200 + 8·n. Bit 8 selects edge sensing (1) or level sensing (0). Bits [3:0] hold the priority level. All other bits read as zero.
- R4: Writing 1 to bit 0 of 0x018 returns every controller register to zero. This covers the masks, setups, edge latches, global enable and in-service state.
- R5: The interrupt output stays low while bit 0 of the global-enable register (0x01C) is 0.
- R6: With global enable set and the controller not in service, the output is high exactly while some source is both pending and enabled.
- R7: A level-sensed source is pending while its synchronised input is high. The input passes through two synchronising flops.
- R8: A level-sensed source is pending while its synchronised input is high.
- R9: An edge-sensed source latches pending on a rising input. It stays pending after the input falls. A write to its setup register clears the latch.
- R10: Among pending enabled sources, the highest priority level wins. On equal levels the lower source number wins. The vector register (0x010) returns the winner's number.
- R11: The vector register reads 64 when no enabled source is pending.
- R12: A vector read that returns a valid source enters the in-service state, and the output goes low from the next cycle. A write of any value to 0x014 leaves the in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Interrupt request lines, asynchronous |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_out | output | 1 | Interrupt request to processor |

## Verification
The priority encoder is exercised with three sources raised together. One pattern has equal levels at numbers 10 and 40, which separates the tie-break on number from any other order. Raising source 40's level then shows that level outranks number, and masking it shows that disabled sources drop out of the choice. Edge sensing is told apart from level sensing in two ways: the input is lowered after a pulse while the source stays pending, and the setup is rewritten while the input is still high, which must leave nothing pending. The in-service gate is shown by the output falling after a valid vector read and returning after an end-of-interrupt write.

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int PRIO_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] irq_in,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [9:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_out
);
  localparam int NSRC = 64;
  localparam logic [9:0] A_ENL = 10'h000, A_ENH = 10'h004, A_DISL = 10'h008,
                         A_DISH = 10'h00C, A_VEC = 10'h010, A_EOI = 10'h014,
                         A_RST = 10'h018, A_GEN = 10'h01C;
  localparam logic [6:0] NO_VEC = 7'd64;

  logic [NSRC-1:0] s1, s2, s3, en_q, esel_q, edge_q, pend, act;
  logic [PRIO_W-1:0] lvl_q [NSRC];
  logic gena_q, busy_q, found;
  logic [5:0] best_idx;
  logic [PRIO_W-1:0] best_lvl;
  logic [6:0] vec;

  wire wr       = bus_sel & bus_wr;
  wire rd       = bus_sel & ~bus_wr;
  wire is_setup = bus_addr[9] && (bus_addr[2:0] == 3'd0);
  wire [5:0] wsrc = bus_addr[8:3];
  wire soft_rst = wr && (bus_addr == A_RST) && bus_wdata[0];
  wire setup_wr = wr && is_setup;
  wire vec_rd   = rd && (bus_addr == A_VEC);

  assign pend    = (esel_q & edge_q) | (~esel_q & s2);
  assign act     = pend & en_q;
  assign vec     = found ? {1'b0, best_idx} : NO_VEC;
  assign irq_out = gena_q & (|act) & ~busy_q;

  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_lvl = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (act[i] && (!found || lvl_q[i] > best_lvl)) begin
        found    = 1'b1;
        best_idx = 6'(i);
        best_lvl = lvl_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= irq_in; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; esel_q <= '0; edge_q <= '0; gena_q <= 1'b0; busy_q <= 1'b0;
      for (int i = 0; i < NSRC; i++) lvl_q[i] <= '0;
    end else if (soft_rst) begin
      en_q <= '0; esel_q <= '0; edge_q <= '0; gena_q <= 1'b0; busy_q <= 1'b0;
      for (int i = 0; i < NSRC; i++) lvl_q[i] <= '0;
    end else begin
      if (wr && bus_addr == A_ENL)  en_q[31:0]  <= en_q[31:0]  | bus_wdata;
      if (wr && bus_addr == A_ENH)  en_q[63:32] <= en_q[63:32] | bus_wdata;
      if (wr && bus_addr == A_DISL) en_q[31:0]  <= en_q[31:0]  & ~bus_wdata;
      if (wr && bus_addr == A_DISH) en_q[63:32] <= en_q[63:32] & ~bus_wdata;
      if (wr && bus_addr == A_GEN)  gena_q <= bus_wdata[0];
      if (wr && bus_addr == A_EOI)  busy_q <= 1'b0;
      else if (vec_rd && found)     busy_q <= 1'b1;
      for (int i = 0; i < NSRC; i++) begin
        if (setup_wr && wsrc == 6'(i)) begin
          esel_q[i] <= bus_wdata[8];
          lvl_q[i]  <= bus_wdata[PRIO_W-1:0];
          edge_q[i] <= 1'b0;
        end else if (esel_q[i] && s2[i] && !s3[i]) begin
          edge_q[i] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (is_setup) begin
      bus_rdata[8]          = esel_q[wsrc];
      bus_rdata[PRIO_W-1:0] = lvl_q[wsrc];
    end else begin
      case (bus_addr)
        A_ENL:   bus_rdata = en_q[31:0];
        A_ENH:   bus_rdata = en_q[63:32];
        A_VEC:   bus_rdata = {25'd0, vec};
        A_GEN:   bus_rdata = {31'd0, gena_q};
        default: bus_rdata = '0;
      endcase
    end
  end

  // R1
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_ENL) |=> en_q[31:0] == ($past(en_q[31:0]) | $past(bus_wdata)));
  // R2
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_DISH) |=> en_q[63:32] == ($past(en_q[63:32]) & ~$past(bus_wdata)));
  // R4
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (en_q == '0 && !gena_q && !irq_out));
  // R9
  edge_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_wr |=> !edge_q[$past(wsrc)]);
  // R11
  no_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !(|act)) |-> bus_rdata == 32'd64);
  // R12
  in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && found) |=> !irq_out);
endmodule

// File: tb/test_irq_hub.sv
module test_irq_hub;
  logic clk = 0, rst_n = 0;
  logic [63:0] irq_in = '0;
  logic bus_sel = 0, bus_wr = 0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_out;
  int checks = 0, errors = 0;
  logic [31:0] r;

  localparam logic [9:0] ENL = 10'h000, ENH = 10'h004, DISL = 10'h008,
                         DISH = 10'h00C, VEC = 10'h010, EOI = 10'h014,
                         RST = 10'h018, GEN = 10'h01C;

  irq_hub i_irq_hub (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  always #5 clk = ~clk;

  function automatic logic [9:0] setup_a(int n);
    return 10'(10'h200 + 8 * n);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    rd(ENL, r); check("R4 reset mask", r, 0);
    rd(VEC, r); check("R11 empty vector", r, 64);
    check("R5 reset irq_out", {31'd0, irq_out}, 0);
  endtask

  task automatic t_enables();
    wr(ENL, 32'h0000_00F0); wr(ENH, 32'h8000_0001);
    rd(ENL, r); check("R1 low mask", r, 32'h0000_00F0);
    rd(ENH, r); check("R1 high mask", r, 32'h8000_0001);
    wr(ENL, 32'h0000_0100);
    rd(ENL, r); check("R1 set keeps others", r, 32'h0000_01F0);
    wr(DISL, 32'h0000_0030);
    rd(ENL, r); check("R2 clear low", r, 32'h0000_01C0);
    wr(DISH, 32'h0000_0001);
    rd(ENH, r); check("R2 clear high", r, 32'h8000_0000);
    rd(DISL, r); check("R2 disable reads zero", r, 0);
  endtask

  task automatic t_setup();
    wr(setup_a(5), 32'h0000_010A);
    rd(setup_a(5), r); check("R3 setup readback", r, 32'h10A);
    wr(setup_a(6), 32'hFFFF_FFFF);
    rd(setup_a(6), r); check("R3 unused bits zero", r, 32'h10F);
    rd(setup_a(7), r); check("R3 neighbour untouched", r, 0);
  endtask

  task automatic t_level();
    wr(RST, 1);
    wr(setup_a(3), 2); wr(ENL, 32'h8);
    irq_in[3] = 1; settle();
    check("R5 gated by global enable", {31'd0, irq_out}, 0);
    wr(GEN, 1); #1;
    check("R6 output high", {31'd0, irq_out}, 1);
    check("R8 level pending", {31'd0, irq_out}, 1);
    @(negedge clk); irq_in[3] = 0;
    @(posedge clk); #1;
    check("R7 one sync stage not enough", {31'd0, irq_out}, 1);
    settle();
    check("R6 output low after input falls", {31'd0, irq_out}, 0);
    rd(VEC, r); check("R8 level released", r, 64);
  endtask

  task automatic t_priority();
    wr(setup_a(10), 5); wr(setup_a(40), 5); wr(setup_a(20), 3);
    wr(ENL, (32'h1 << 10) | (32'h1 << 20)); wr(ENH, 32'h1 << 8);
    irq_in[10] = 1; irq_in[40] = 1; irq_in[20] = 1; settle();
    rd(VEC, r); check("R10 tie lower number", r, 10); wr(EOI, 0);
    wr(setup_a(40), 7);
    rd(VEC, r); check("R10 higher level wins", r, 40); wr(EOI, 0);
    wr(DISH, 32'h1 << 8);
    rd(VEC, r); check("R10 masked source skipped", r, 10); wr(EOI, 0);
    wr(DISL, 32'h1 << 10);
    rd(VEC, r); check("R10 low level alone", r, 20); wr(EOI, 0);
    irq_in[10] = 0; irq_in[40] = 0; irq_in[20] = 0;
    wr(DISL, 32'hFFFF_FFFF); settle();
  endtask

  task automatic t_edge();
    wr(setup_a(50), 32'h101); wr(ENH, 32'h1 << 18);
    @(negedge clk); irq_in[50] = 1; repeat (3) @(negedge clk); irq_in[50] = 0;
    settle();
    rd(VEC, r); check("R9 edge held after fall", r, 50); wr(EOI, 0);
    wr(setup_a(50), 32'h101);
    rd(VEC, r); check("R9 setup write clears", r, 64);
    @(negedge clk); irq_in[50] = 1; settle();
    wr(setup_a(50), 32'h101);
    rd(VEC, r); check("R9 high input no new edge", r, 64);
    irq_in[50] = 0; settle();
  endtask

  task automatic t_service();
    wr(setup_a(2), 1); wr(ENL, 32'h4); wr(GEN, 1);
    irq_in[2] = 1; settle();
    check("R6 asserted", {31'd0, irq_out}, 1);
    rd(VEC, r); check("R12 vector", r, 2); #1;
    check("R12 masked in service", {31'd0, irq_out}, 0);
    wr(EOI, 32'h1234); #1;
    check("R12 EOI releases", {31'd0, irq_out}, 1);
  endtask

  task automatic t_softreset();
    wr(RST, 0); #1;
    check("R4 bit0 clear ignored", {31'd0, irq_out}, 1);
    wr(RST, 1); #1;
    check("R4 output cleared", {31'd0, irq_out}, 0);
    rd(ENL, r); check("R4 mask cleared", r, 0);
    rd(setup_a(2), r); check("R4 setup cleared", r, 0);
    rd(GEN, r); check("R4 global enable cleared", r, 0);
    irq_in = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_enables(); t_setup(); t_level();
    t_priority(); t_edge(); t_service(); t_softreset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule